// File: doc/BRIEF.md
# Serial Companion-Chip Register Bridge

This block gives a host processor access to the 16-bit registers of an external power-management companion chip over a four-wire serial link. The host sees a small 32-bit register bus. A 4 KiB window at offset 0x8000 maps directly onto the companion chip's registers. A host write that lands in the window is placed in a write queue, and the queue is drained one serial frame at a time.

Reads are posted. The host writes the wanted register address to the read-command register. The bridge raises a busy flag and waits until every queued write has gone out and the link is idle. It then runs a read frame. When the frame finishes, it stores the returned data together with the address that was read. Software polls the result register until busy drops, and it can compare the echoed address against the address it asked for.

Top module: `pmic_link_bridge`

## Requirements
- R1: A host write to a byte address in 0x8000..0x8FFF is sent as one serial write frame. The frame carries address bits 11:0 of the bus address and data bits 15:0 of the bus data.
- R2: A host write to offset 0x28 starts a serial read of the register given by write-data bits 11:0. No separate start action is needed.
- R3: Bit 31 of the result register at offset 0x2C reads 1 from the first cycle after a read command is taken. It stays 1 until that read's frame has completed.
- R4: After a read completes, bits 15:0 of offset 0x2C hold the returned value. Bits 30:16 hold the requested address masked to bits 11:0, and bit 31 is 0.
- R5: The queue-status register at offset 0x30 reads bit 11 = 1 exactly when the write queue is full. It reads bit 10 = 1 exactly when the queue is empty, and all other bits read 0.
- R6: A window write that arrives while the queue is full is dropped, and the slave register it names is left unchanged.
- R7: The write queue holds 8 entries. Queued writes reach the serial link in the order the host issued them.
- R8: A read frame starts only when the write queue is empty and no frame is in progress. A read therefore returns data written by any write issued before the read command.
- R9: A frame is 29 bits sent most significant bit first while the active-low select is held low: a direction bit (1 = read, 0 = write), then 12 address bits, then 16 data bits. The serial clock idles low, the host output changes after falling edges, and read data is sampled on rising edges.
- R10: A read command written while bit 31 of offset 0x2C is 1 is ignored. The read already in progress finishes and reports its own address and data.
- R11: After reset the queue is empty, offset 0x2C reads 0, and the select line is high with the serial clock low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register bus access strobe |
| bus_wr | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | 16 | Byte address within the bridge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from address) |
| ser_csn | output | 1 | Serial select, active low |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_mosi | output | 1 | Serial data towards the companion chip |
| ser_miso | input | 1 | Serial data from the companion chip |

## Verification
Two situations are hard to reach: a full queue meeting one more write, and a read command arriving while writes are still queued. Back-to-back single-cycle window writes fill the queue faster than one frame can drain it. These are followed at once by a read of the queue status and a read-back of the dropped address. For ordering, writes and a read command of the same register are issued on consecutive cycles. A second read command is issued while the first is busy. A behavioural serial slave in the bench decodes every frame from the pins and serves read data. A per-cycle occupancy model tracks the queue flags and the read-frame start condition.

// File: rtl/pmb_pkg.sv
package pmb_pkg;
   localparam int unsigned REG_RD_CMD     = 32'h28;
   localparam int unsigned REG_RD_RESULT  = 32'h2C;
   localparam int unsigned REG_LINK_STAT  = 32'h30;
   localparam int unsigned STAT_FULL_BIT  = 11;
   localparam int unsigned STAT_EMPTY_BIT = 10;
   localparam int unsigned RESULT_BUSY    = 31;

   typedef enum logic { ENG_IDLE = 1'b0, ENG_SHIFT = 1'b1 } eng_state_e;
endpackage

// File: rtl/pmb_wfifo.sv
module pmb_wfifo #(
   parameter int W     = 28,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("pmb_wfifo: DEPTH must be at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp, wp_nxt, rp_nxt;
   logic [CW-1:0] cnt;
   logic          push_ok, pop_ok;

   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign dout    = mem[rp];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wp_nxt = wp + 1'b1;
         assign rp_nxt = rp + 1'b1;
      end else begin : g_wrap
         assign wp_nxt = (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_nxt = (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push_ok) wp <= wp_nxt;
         if (pop_ok)  rp <= rp_nxt;
         case ({push_ok, pop_ok})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !pop) |=> full); // R6
   AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty)); // R5
   AST_POP_DROPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (full && pop && !push) |=> !full); // R7
endmodule

// File: rtl/pmb_serial_engine.sv
module pmb_serial_engine import pmb_pkg::*; #(
   parameter int AW       = 12,
   parameter int DW       = 16,
   parameter int HALF_DIV = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          start_rd,
   input  logic [AW-1:0] start_addr,
   input  logic [DW-1:0] start_data,
   output logic          idle,
   output logic          done,
   output logic [DW-1:0] rx_data,
   output logic          sclk,
   output logic          csn,
   output logic          mosi,
   input  logic          miso
);
   localparam int FRAME = 1 + AW + DW;
   localparam int BCW   = $clog2(FRAME);

   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("pmb_serial_engine: HALF_DIV must be at least 1");
      end
   endgenerate

   eng_state_e     st;
   logic [FRAME-1:0] tx;
   logic [BCW-1:0] bitn;
   logic           tick;

   generate
      if (HALF_DIV == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         localparam int HCW = $clog2(HALF_DIV);
         logic [HCW-1:0] hcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                         hcnt <= '0;
            else if (st == ENG_IDLE || hcnt == HCW'(HALF_DIV - 1)) hcnt <= '0;
            else                                                hcnt <= hcnt + 1'b1;
         end
         assign tick = (hcnt == HCW'(HALF_DIV - 1));
      end
   endgenerate

   assign idle = (st == ENG_IDLE);
   assign mosi = tx[FRAME-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ENG_IDLE;
         tx      <= '0;
         bitn    <= '0;
         sclk    <= 1'b0;
         csn     <= 1'b1;
         done    <= 1'b0;
         rx_data <= '0;
      end else begin
         done <= 1'b0;
         case (st)
            ENG_IDLE: begin
               if (start) begin
                  st   <= ENG_SHIFT;
                  csn  <= 1'b0;
                  sclk <= 1'b0;
                  bitn <= '0;
                  tx   <= {start_rd, start_addr, start_data};
               end
            end
            ENG_SHIFT: begin
               if (tick) begin
                  if (!sclk) begin
                     sclk    <= 1'b1;
                     rx_data <= {rx_data[DW-2:0], miso};
                  end else begin
                     sclk <= 1'b0;
                     if (bitn == BCW'(FRAME - 1)) begin
                        st   <= ENG_IDLE;
                        csn  <= 1'b1;
                        done <= 1'b1;
                     end else begin
                        bitn <= bitn + 1'b1;
                        tx   <= {tx[FRAME-2:0], 1'b0};
                     end
                  end
               end
            end
         endcase
      end
   end

   AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
      csn |-> !sclk); // R9
   AST_DONE_DESELECTS: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> csn); // R9
   AST_MOSI_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (!csn && $rose(sclk)) |-> $stable(mosi)); // R9
endmodule

// File: rtl/pmic_link_bridge.sv
module pmic_link_bridge import pmb_pkg::*; #(
   parameter int                BUS_AW     = 16,
   parameter int                ADDR_W     = 12,
   parameter int                DATA_W     = 16,
   parameter int                FIFO_DEPTH = 8,
   parameter int                HALF_DIV   = 2,
   parameter logic [BUS_AW-1:0] WIN_BASE   = 16'h8000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              ser_csn,
   output logic              ser_clk,
   output logic              ser_mosi,
   input  logic              ser_miso
);
   localparam int ENTRY_W = ADDR_W + DATA_W;

   generate
      if (ENTRY_W > 31) begin : g_bad_result
         $error("pmic_link_bridge: address and data do not fit the result word");
      end
      if (BUS_AW <= ADDR_W) begin : g_bad_bus
         $error("pmic_link_bridge: bus address must be wider than the window");
      end
   endgenerate

   logic               win_wr, cmd_wr;
   logic               fifo_full, fifo_empty, fifo_pop;
   logic [ENTRY_W-1:0] fifo_dout;
   logic               eng_idle, eng_done, eng_start, wr_go, rd_go;
   logic [ADDR_W-1:0]  eng_addr;
   logic [DATA_W-1:0]  eng_data, eng_rx;
   logic               busy_q, rd_started_q;
   logic [ADDR_W-1:0]  rd_addr_q, res_addr_q;
   logic [DATA_W-1:0]  res_data_q;
   logic [31:0]        rd_word, stat_word;
   logic               unused_wdata_hi;

   assign unused_wdata_hi = ^bus_wdata[31:DATA_W];

   assign win_wr = bus_sel && bus_wr &&
                   (bus_addr[BUS_AW-1:ADDR_W] == WIN_BASE[BUS_AW-1:ADDR_W]);
   assign cmd_wr = bus_sel && bus_wr && (bus_addr == BUS_AW'(REG_RD_CMD));

   pmb_wfifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_wfifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (win_wr),
      .din   ({bus_addr[ADDR_W-1:0], bus_wdata[DATA_W-1:0]}),
      .pop   (fifo_pop),
      .dout  (fifo_dout),
      .full  (fifo_full),
      .empty (fifo_empty)
   );

   assign wr_go     = eng_idle && !fifo_empty;
   assign rd_go     = eng_idle && fifo_empty && busy_q && !rd_started_q;
   assign eng_start = wr_go || rd_go;
   assign fifo_pop  = wr_go;
   assign eng_addr  = wr_go ? fifo_dout[ENTRY_W-1:DATA_W] : rd_addr_q;
   assign eng_data  = wr_go ? fifo_dout[DATA_W-1:0] : '0;

   pmb_serial_engine #(.AW(ADDR_W), .DW(DATA_W), .HALF_DIV(HALF_DIV)) u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (eng_start),
      .start_rd   (!wr_go),
      .start_addr (eng_addr),
      .start_data (eng_data),
      .idle       (eng_idle),
      .done       (eng_done),
      .rx_data    (eng_rx),
      .sclk       (ser_clk),
      .csn        (ser_csn),
      .mosi       (ser_mosi),
      .miso       (ser_miso)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q       <= 1'b0;
         rd_started_q <= 1'b0;
         rd_addr_q    <= '0;
         res_addr_q   <= '0;
         res_data_q   <= '0;
      end else begin
         if (cmd_wr && !busy_q) begin
            busy_q    <= 1'b1;
            rd_addr_q <= bus_wdata[ADDR_W-1:0];
         end
         if (rd_go) rd_started_q <= 1'b1;
         if (eng_done && rd_started_q) begin
            busy_q       <= 1'b0;
            rd_started_q <= 1'b0;
            res_addr_q   <= rd_addr_q;
            res_data_q   <= eng_rx;
         end
      end
   end

   always_comb begin
      rd_word                      = '0;
      rd_word[RESULT_BUSY]         = busy_q;
      rd_word[DATA_W +: ADDR_W]    = res_addr_q;
      rd_word[DATA_W-1:0]          = res_data_q;
      stat_word                    = '0;
      stat_word[STAT_FULL_BIT]     = fifo_full;
      stat_word[STAT_EMPTY_BIT]    = fifo_empty;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         if (bus_addr == BUS_AW'(REG_RD_RESULT))      bus_rdata = rd_word;
         else if (bus_addr == BUS_AW'(REG_LINK_STAT)) bus_rdata = stat_word;
      end
   end

   AST_BUSY_RISES: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && !busy_q) |=> busy_q); // R3
   AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !(eng_done && rd_started_q)) |=> busy_q); // R3
   AST_READ_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_started_q) |-> ($past(fifo_empty) && !ser_csn)); // R8
   AST_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && busy_q) |=> $stable(rd_addr_q)); // R10
   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |=> $stable(res_data_q) && $stable(res_addr_q)); // R4
endmodule

// File: tb/sim_pmic_link_bridge.sv
module sim_pmic_link_bridge;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_sel, bus_wr;
   logic [15:0] bus_addr;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata;
   logic        ser_csn, ser_clk, ser_mosi;
   logic        ser_miso = 1'b0;

   int tests = 0;
   int fails = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   pmic_link_bridge u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ser_csn(ser_csn), .ser_clk(ser_clk), .ser_mosi(ser_mosi), .ser_miso(ser_miso)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] dflt(input logic [11:0] a);
      return {a[3:0], a} ^ 16'hC35A;
   endfunction

   // ---------------- behavioural serial slave ----------------
   logic [15:0] smem [logic [11:0]];
   logic [27:0] exp_q [$];
   int          scnt = 0;
   logic [28:0] sbits;
   logic        s_rw = 1'b0;
   logic [11:0] s_addr;
   logic [15:0] s_rval;
   int          wr_frames = 0;
   int          rd_frames = 0;

   function automatic logic [15:0] slave_get(input logic [11:0] a);
      if (smem.exists(a)) return smem[a];
      return dflt(a);
   endfunction

   always @(posedge ser_clk or posedge ser_csn) begin
      if (ser_csn) scnt = 0;
      else begin
         sbits = {sbits[27:0], ser_mosi};
         scnt++;
         if (scnt == 13) begin
            s_rw   = sbits[12];
            s_addr = sbits[11:0];
            if (s_rw) begin
               s_rval = slave_get(s_addr);
               rd_frames++;
            end
         end
         if (scnt == 29 && !s_rw) begin
            wr_frames++;
            if (exp_q.size() == 0) check(1'b0, "R7 unexpected write frame", {4'h0, s_addr, sbits[15:0]}, 32'h0);
            else begin
               logic [27:0] e;
               e = exp_q.pop_front();
               check({s_addr, sbits[15:0]} == e, "R1/R7 write frame content/order",
                     {4'h0, s_addr, sbits[15:0]}, {4'h0, e});
            end
            smem[s_addr] = sbits[15:0];
         end
      end
   end

   always @(negedge ser_clk) begin
      if (!ser_csn && s_rw && scnt >= 13 && scnt <= 28) ser_miso = s_rval[28 - scnt];
      else ser_miso = 1'b0;
   end

   // ---------------- per-cycle occupancy model ----------------
   int   m_cnt = 0;
   bit   m_pend = 0;
   logic prev_csn = 1'b1;

   always @(negedge clk) begin
      if (rst_n === 1'b1) begin
         bit fell;
         fell = prev_csn && !ser_csn;
         if (fell && ser_mosi) check(m_cnt == 0, "R8 read frame with queued writes", m_cnt, 0);
         m_cnt = m_cnt + (m_pend ? 1 : 0) - ((fell && !ser_mosi) ? 1 : 0);
         if (ser_csn) check(ser_clk == 1'b0, "R9 clock parked while deselected", ser_clk, 0);
         if (bus_sel && !bus_wr && bus_addr == 16'h0030)
            check(bus_rdata == {20'h0, (m_cnt == 8), (m_cnt == 0), 10'h0},
                  "R5 queue status flags", bus_rdata, {20'h0, (m_cnt == 8), (m_cnt == 0), 10'h0});
         m_pend = bus_sel && bus_wr && bus_addr[15:12] == 4'h8 && m_cnt != 8;
         if (m_pend) exp_q.push_back({bus_addr[11:0], bus_wdata[15:0]});
         prev_csn = ser_csn;
      end
   end

   // ---------------- bus tasks ----------------
   task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
      @(posedge clk); #2;
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
   endtask

   task automatic bus_idle();
      @(posedge clk); #2;
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [15:0] a, output logic [31:0] v);
      @(posedge clk); #2;
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      v = bus_rdata;
   endtask

   task automatic wait_read(output logic [31:0] v);
      int n = 0;
      do begin
         bus_read(16'h002C, v);
         n++;
      end while (v[31] && n < 5000);
   endtask

   task automatic wait_drain();
      logic [31:0] v;
      int n = 0;
      do begin
         bus_read(16'h0030, v);
         n++;
      end while (!(v[10] && ser_csn) && n < 5000);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         tests++; fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      int rf;
      rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
      repeat (5) @(posedge clk);
      #2 rst_n = 1'b1;

      // R11 reset state
      bus_read(16'h002C, v);
      check(v == 32'h0, "R11 result register after reset", v, 32'h0);
      bus_read(16'h0030, v);
      check(v == 32'h400, "R11 queue empty after reset", v, 32'h400);
      check(ser_csn == 1'b1 && ser_clk == 1'b0, "R11 serial pins idle", {ser_csn, ser_clk}, 2'b10);

      // R1 single window write
      bus_write(16'h8123, 32'hFFFFBEEF);
      bus_idle();
      wait_drain();
      check(wr_frames == 1, "R1 one write frame sent", wr_frames, 1);

      // R2 R3 R4 read with high address bits set
      bus_write(16'h0028, 32'h00007123);
      bus_read(16'h002C, v);
      check(v[31] == 1'b1, "R3 busy right after command", v, 32'h80000000);
      wait_read(v);
      check(v == {1'b0, 15'h0123, 16'hBEEF}, "R2/R4 read result and echoed address", v, {1'b0, 15'h0123, 16'hBEEF});

      // R9 read of never-written register, all address bits set
      bus_write(16'h0028, 32'h00000FFF);
      bus_idle();
      wait_read(v);
      check(v == {1'b0, 15'h0FFF, dflt(12'hFFF)}, "R9 read frame data sampling", v, {1'b0, 15'h0FFF, dflt(12'hFFF)});

      // R5 R6 R7 burst into a full queue
      for (int i = 0; i < 10; i++) bus_write(16'h8200 + 16'(i), 32'h1000 + i);
      bus_read(16'h0030, v);
      check(v == 32'h800, "R5 queue reports full", v, 32'h800);
      wait_drain();
      check(v != 32'h0 && wr_frames == 10, "R7 eight queued plus one in flight delivered", wr_frames, 10);
      bus_write(16'h0028, 32'h208);
      bus_idle();
      wait_read(v);
      check(v == {1'b0, 15'h0208, 16'h1008}, "R7 last accepted write landed", v, {1'b0, 15'h0208, 16'h1008});
      bus_write(16'h0028, 32'h209);
      bus_idle();
      wait_read(v);
      check(v == {1'b0, 15'h0209, dflt(12'h209)}, "R6 write while full dropped", v, {1'b0, 15'h0209, dflt(12'h209)});

      // R8 read issued right behind queued writes to the same register
      bus_write(16'h8300, 32'h1234);
      bus_write(16'h8301, 32'h5678);
      bus_write(16'h0028, 32'h300);
      bus_idle();
      wait_read(v);
      check(v == {1'b0, 15'h0300, 16'h1234}, "R8 read ordered after writes", v, {1'b0, 15'h0300, 16'h1234});

      // R10 second command while busy
      rf = rd_frames;
      bus_write(16'h0028, 32'h123);
      bus_write(16'h0028, 32'h301);
      bus_idle();
      wait_read(v);
      check(v == {1'b0, 15'h0123, 16'hBEEF}, "R10 in-flight read kept", v, {1'b0, 15'h0123, 16'hBEEF});
      repeat (300) @(posedge clk);
      bus_read(16'h002C, v);
      check(v[31] == 1'b0 && rd_frames == rf + 1, "R10 ignored command starts no frame", rd_frames, rf + 1);

      wait_drain();
      check(exp_q.size() == 0, "R7 every accepted write delivered", exp_q.size(), 0);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule